// File: doc/BRIEF.md
# Cascaded Search Result Latency Stage

This block belongs to one device in a table built from several lookup devices stacked in depth. Each cycle it accepts a search request or an SRAM read request, together with that cycle's local match result, a cascade-wide "some device matched" indication and a flag saying whether this device owns the SRAM read. The request travels down a token pipeline and reappears on the outputs after a fixed latency.

The latency has two parts. A base latency is chosen by a table-depth code and applies to the shared SRAM address and strobes. An extra 0 to 7 cycle delay is added on top, but only for the match result pins and the read acknowledge.

Because the result and SRAM pins are shared by all devices in the stack, the block also decides for every output cycle whether this device drives them or leaves them released. Per-group drive enables stand in for the tri-state buffers. One device, marked as the tail of the stack, is the default driver of the result pins. One device, marked as the tail of the SRAM bus, is the default driver of the SRAM pins.

Top module: `casc_result_delay`

## Requirements
- R1: A request sampled in cycle c drives the SRAM outputs in cycle c+L. The base latency L is 4 for `cfg_depth_sel`=0, 5 for 1 and 6 for 2.
- R2: `cfg_depth_sel`=3 gives L=6 and sets `cfg_err`=1. Every other code gives `cfg_err`=0.
- R3: The result pins and the acknowledge appear in cycle c+L+H, where H is the value of `cfg_extra_lat` (0..7). The SRAM outputs stay at c+L whatever H is.
- R4: A search that hits locally gives `res_found`=1, `res_valid`=1 and `res_oe`=1 in cycle c+L+H. In cycle c+L it drives `ram_addr` to the request address with `ram_ce_n`=0, `ram_ale_n`=0, `ram_we_n`=1 and `ram_drv`=1.
- R5: With `cfg_tail_dev`=1, a search that no device hits gives `res_found`=0, `res_valid`=1 and `res_oe`=1.
- R6: In an output cycle that carries no search, a device with `cfg_tail_dev`=1 drives `res_found`=0, `res_valid`=0 and `res_oe`=1. A device with `cfg_tail_dev`=0 has `res_oe`=0. A search that no device hits also leaves a device with `cfg_tail_dev`=0 released.
- R7: An SRAM read with `bus_own`=1 drives `ram_addr`=address, `ram_ce_n`=0, `ram_ale_n`=0, `ram_we_n`=1 and `ram_drv`=1 in cycle c+L. It gives `rack`=1 and `rack_oe`=1 in cycle c+L+H. In all other cases `rack`=0 and `rack_oe`=0.
- R8: The SRAM bus is idle in an output cycle when that cycle carries neither a read nor a search hit in any device. In an idle cycle, a device with `cfg_tail_bus`=1 drives `ram_addr`=all ones, `ram_ce_n`=`ram_we_n`=`ram_ale_n`=1 and `ram_drv`=1. Whenever `ram_drv`=0, `ram_addr` reads 0 and all three strobes read 1.
- R9: `ram_rd_drv` equals `cfg_tail_bus` in every cycle. `ram_rd_n` is 0 only when `cfg_tail_bus`=1 and the base output cycle carries a read or a search hit from any device. Otherwise it is 1.
- R10: Requests in consecutive cycles each come out at their own latency, without loss or merging.
- R11: During and after reset the pipeline holds no request. Outputs take their idle values, and a request in flight when reset arrives never reaches the outputs.
- R12: When another device hits (`hit_any`=1, `hit_loc`=0), or another device owns a read, this device releases the result pins (or the acknowledge) and the SRAM pins even if it is a default driver. It still drives `ram_rd_n`=0 if `cfg_tail_bus`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_depth_sel | input | 2 | Table-depth code selecting base latency |
| cfg_extra_lat | input | 3 | Extra delay for result and acknowledge |
| cfg_tail_dev | input | 1 | Default driver of the result pins |
| cfg_tail_bus | input | 1 | Default driver of the SRAM pins and read strobe |
| req_srch | input | 1 | Search request this cycle |
| req_rd | input | 1 | SRAM read request this cycle |
| req_addr | input | 22 | SRAM address for the request |
| hit_loc | input | 1 | This device matched the search |
| hit_any | input | 1 | Some device in the stack matched |
| bus_own | input | 1 | This device owns the SRAM read |
| res_found | output | 1 | Match-found result pin |
| res_valid | output | 1 | Result-valid pin |
| res_oe | output | 1 | Drive enable of the result pins |
| rack | output | 1 | SRAM read acknowledge |
| rack_oe | output | 1 | Drive enable of the acknowledge |
| ram_addr | output | 22 | SRAM address |
| ram_ce_n | output | 1 | SRAM chip enable, active low |
| ram_we_n | output | 1 | SRAM write enable, active low |
| ram_ale_n | output | 1 | SRAM address latch enable, active low |
| ram_drv | output | 1 | Drive enable of address and strobes |
| ram_rd_n | output | 1 | SRAM output enable, active low |
| ram_rd_drv | output | 1 | Drive enable of the output enable |
| cfg_err | output | 1 | Reserved depth code selected |

## Verification
A request presented before the rising edge that ends cycle 0 has its SRAM outputs due in cycle L and its result and acknowledge due in cycle L+H. Every other cycle must show idle or default values. The bench drives each request on a falling edge and compares the whole output word on each of the following 16 falling edges, so an output one cycle early or late shows up as a mismatch. A back-to-back sequence checks three requests against their own due cycles, and a reset in mid-flight checks that the slot where the lost request was due stays idle.

// File: rtl/casc_result_delay.sv
module casc_result_delay #(
  parameter int AW   = 22,
  parameter int HLW  = 3,
  parameter int LAT0 = 4,
  parameter int LAT1 = 5,
  parameter int LAT2 = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_depth_sel,
  input  logic [HLW-1:0] cfg_extra_lat,
  input  logic          cfg_tail_dev,
  input  logic          cfg_tail_bus,
  input  logic          req_srch,
  input  logic          req_rd,
  input  logic [AW-1:0] req_addr,
  input  logic          hit_loc,
  input  logic          hit_any,
  input  logic          bus_own,
  output logic          res_found,
  output logic          res_valid,
  output logic          res_oe,
  output logic          rack,
  output logic          rack_oe,
  output logic [AW-1:0] ram_addr,
  output logic          ram_ce_n,
  output logic          ram_we_n,
  output logic          ram_ale_n,
  output logic          ram_drv,
  output logic          ram_rd_n,
  output logic          ram_rd_drv,
  output logic          cfg_err
);

  localparam int DEPTH = LAT2 + (1 << HLW) - 1;
  localparam int IW    = $clog2(DEPTH + 1);

  typedef struct packed {
    logic          srch;
    logic          rd;
    logic          loc;
    logic          any;
    logic          own;
    logic [AW-1:0] addr;
  } tok_t;

  tok_t pipe [1:DEPTH];
  tok_t in_tok;
  tok_t bt;
  logic [IW-1:0] base_lat, hit_lat;
  logic h_srch, h_rd, h_loc, h_any, h_own;
  logic b_act, b_busy;

  assign in_tok = '{srch: req_srch, rd: req_rd, loc: hit_loc, any: hit_any,
                    own: bus_own, addr: req_addr};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 1; i <= DEPTH; i++) pipe[i] <= '0;
    end else begin
      pipe[1] <= in_tok;
      for (int i = 2; i <= DEPTH; i++) pipe[i] <= pipe[i-1];
    end
  end

  always_comb begin
    case (cfg_depth_sel)
      2'd0:    base_lat = IW'(LAT0);
      2'd1:    base_lat = IW'(LAT1);
      default: base_lat = IW'(LAT2);
    endcase
  end

  assign cfg_err = &cfg_depth_sel;
  assign hit_lat = base_lat + IW'(cfg_extra_lat);

  assign bt     = pipe[base_lat];
  assign b_act  = (bt.srch & bt.loc) | (bt.rd & bt.own);
  assign b_busy = (bt.srch & bt.any) | bt.rd;

  always_comb begin
    if (b_act) begin
      ram_addr = bt.addr;
      {ram_ce_n, ram_we_n, ram_ale_n, ram_drv} = 4'b0101;
    end else if (!b_busy && cfg_tail_bus) begin
      ram_addr = '1;
      {ram_ce_n, ram_we_n, ram_ale_n, ram_drv} = 4'b1111;
    end else begin
      ram_addr = '0;
      {ram_ce_n, ram_we_n, ram_ale_n, ram_drv} = 4'b1110;
    end
  end

  assign ram_rd_drv = cfg_tail_bus;
  assign ram_rd_n   = ~(cfg_tail_bus & b_busy);

  assign h_srch = pipe[hit_lat].srch;
  assign h_rd   = pipe[hit_lat].rd;
  assign h_loc  = pipe[hit_lat].loc;
  assign h_any  = pipe[hit_lat].any;
  assign h_own  = pipe[hit_lat].own;

  assign res_found = h_srch & h_loc;
  assign res_valid = h_srch & (h_loc | (~h_any & cfg_tail_dev));
  assign res_oe    = h_srch ? (h_loc | (~h_any & cfg_tail_dev)) : cfg_tail_dev;
  assign rack      = h_rd & h_own;
  assign rack_oe   = h_rd & h_own;

  AST_FOUND_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (res_oe && res_found) |-> res_valid);                                        // R4
  AST_RES_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !res_oe |-> (!res_found && !res_valid));                                     // R6
  AST_RAM_IDLE_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_drv && ram_ce_n) |-> ((&ram_addr) && ram_we_n && ram_ale_n));           // R8
  AST_RAM_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_drv |-> (ram_addr == '0 && ram_ce_n && ram_we_n && ram_ale_n));         // R8
  AST_ACK_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    rack |-> rack_oe);                                                           // R7
  AST_RD_STROBE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_rd_drv |-> ram_rd_n);                                                   // R9
  AST_ACCESS_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_ce_n |-> (ram_we_n && !ram_ale_n && ram_drv));                          // R7

endmodule

// File: tb/casc_result_delay_tb_top.sv
module casc_result_delay_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_depth_sel = '0;
  logic [2:0] cfg_extra_lat = '0;
  logic cfg_tail_dev = 1'b0, cfg_tail_bus = 1'b0;
  logic req_srch = 1'b0, req_rd = 1'b0, hit_loc = 1'b0, hit_any = 1'b0, bus_own = 1'b0;
  logic [21:0] req_addr = '0;
  logic res_found, res_valid, res_oe, rack, rack_oe;
  logic [21:0] ram_addr;
  logic ram_ce_n, ram_we_n, ram_ale_n, ram_drv, ram_rd_n, ram_rd_drv, cfg_err;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  casc_result_delay dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_depth_sel(cfg_depth_sel), .cfg_extra_lat(cfg_extra_lat),
    .cfg_tail_dev(cfg_tail_dev), .cfg_tail_bus(cfg_tail_bus), .req_srch(req_srch),
    .req_rd(req_rd), .req_addr(req_addr), .hit_loc(hit_loc), .hit_any(hit_any),
    .bus_own(bus_own), .res_found(res_found), .res_valid(res_valid), .res_oe(res_oe),
    .rack(rack), .rack_oe(rack_oe), .ram_addr(ram_addr), .ram_ce_n(ram_ce_n),
    .ram_we_n(ram_we_n), .ram_ale_n(ram_ale_n), .ram_drv(ram_drv), .ram_rd_n(ram_rd_n),
    .ram_rd_drv(ram_rd_drv), .cfg_err(cfg_err)
  );

  // vector: {depth[33:32], extra[31:29], tail_dev[28], tail_bus[27], srch[26], rd[25],
  //          loc[24], any[23], own[22], addr[21:0]}
  localparam int NV = 10;
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 22'h012345},  // R1 R4
    {2'd1, 3'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 22'h000777},  // R3 R5
    {2'd2, 3'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 22'h2AAAAA},  // R3 R4
    {2'd3, 3'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 22'h155555},  // R2 R7
    {2'd1, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 22'h000010},  // R12
    {2'd0, 3'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 22'h000020},  // R12
    {2'd2, 3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 22'h000030},  // R9
    {2'd0, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 22'h000000},  // R6
    {2'd1, 3'd6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 22'h000040},  // R6
    {2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 22'h3FFFFE}   // R7 R8
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R1 R4";   1: return "R3 R5";  2: return "R3 R4";  3: return "R2 R7";
      4: return "R12";     5: return "R12";    6: return "R9";     7: return "R6";
      8: return "R6";      default: return "R7 R8";
    endcase
  endfunction

  // {found, valid, res_oe, rack, rack_oe, addr[22], ce_n, we_n, ale_n, drv, rd_n, rd_drv, err}
  function automatic logic [33:0] model(logic [33:0] v, int k);
    int L, H;
    logic srch, rd, loc, any, own, ldev, lbus, kb, kh, busy, act;
    logic [21:0] a;
    logic [3:0] st;
    logic f, vl, oe, ak;
    L = (v[33:32] == 2'd0) ? 4 : (v[33:32] == 2'd1) ? 5 : 6;
    H = int'(v[31:29]);
    ldev = v[28]; lbus = v[27]; srch = v[26]; rd = v[25];
    loc = v[24]; any = v[23]; own = v[22];
    kb = (k == L); kh = (k == L + H);
    busy = kb && ((srch && any) || rd);
    act  = kb && ((srch && loc) || (rd && own));
    if (act)              begin a = v[21:0]; st = 4'b0101; end
    else if (!busy && lbus) begin a = '1;     st = 4'b1111; end
    else                  begin a = '0;      st = 4'b1110; end
    if (kh && srch) begin
      if (loc)                f = 1'b1;
      else                    f = 1'b0;
      vl = loc || (!any && ldev);
      oe = vl;
    end else begin
      f = 1'b0; vl = 1'b0; oe = ldev;
    end
    ak = kh && rd && own;
    return {f, vl, oe, ak, ak, a, st, ~(lbus && busy), lbus, (v[33:32] == 2'd3)};
  endfunction

  function automatic logic [33:0] got_word();
    return {res_found, res_valid, res_oe, rack, rack_oe, ram_addr, ram_ce_n, ram_we_n,
            ram_ale_n, ram_drv, ram_rd_n, ram_rd_drv, cfg_err};
  endfunction

  task automatic check(input bit ok, input string req, input logic [33:0] got,
                       input logic [33:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic apply_cfg(logic [33:0] v);
    cfg_depth_sel = v[33:32]; cfg_extra_lat = v[31:29];
    cfg_tail_dev = v[28]; cfg_tail_bus = v[27];
  endtask

  task automatic drive_req(logic s, logic r, logic l, logic a, logic o, logic [21:0] ad);
    req_srch = s; req_rd = r; hit_loc = l; hit_any = a; bus_own = o; req_addr = ad;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [33:0] idle_v;
    // R11: outputs during reset, tail device on both buses
    idle_v = {2'd0, 3'd0, 1'b1, 1'b1, 7'd0, 22'd0};
    apply_cfg(idle_v);
    repeat (3) @(negedge clk);
    check(got_word() == model(idle_v, 0), "R11", got_word(), model(idle_v, 0));
    rst_n = 1'b1;

    // table walk: one request, then 16 observed cycles
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply_cfg(VEC[i]);
      drive_req(VEC[i][26], VEC[i][25], VEC[i][24], VEC[i][23], VEC[i][22], VEC[i][21:0]);
      for (int k = 1; k <= 16; k++) begin
        @(negedge clk);
        if (k == 1) drive_req(0, 0, 0, 0, 0, '0);
        check(got_word() == model(VEC[i], k), vtag(i), got_word(), model(VEC[i], k));
      end
    end

    // R10: back-to-back hit, miss, read with depth code 1 and extra delay 2
    @(negedge clk);
    cfg_depth_sel = 2'd1; cfg_extra_lat = 3'd2; cfg_tail_dev = 1'b1; cfg_tail_bus = 1'b1;
    drive_req(1, 0, 1, 1, 0, 22'h0ABCDE);
    @(negedge clk); drive_req(1, 0, 0, 0, 0, 22'h000111);
    @(negedge clk); drive_req(0, 1, 0, 0, 1, 22'h123456);
    for (int k = 3; k <= 10; k++) begin
      @(negedge clk);
      if (k == 3) drive_req(0, 0, 0, 0, 0, '0);
      if (k == 5) check(ram_addr == 22'h0ABCDE && !ram_ce_n, "R10 first", got_word(), 34'h0);
      if (k == 6) check(ram_addr == 22'h3FFFFF && ram_ce_n && ram_drv, "R10 second",
                        got_word(), 34'h0);
      if (k == 7) check(ram_addr == 22'h123456 && res_found && res_valid && !rack,
                        "R10 third", got_word(), 34'h0);
      if (k == 8) check(!res_found && res_valid && res_oe, "R10 miss", got_word(), 34'h0);
      if (k == 9) check(rack && rack_oe && !res_valid && res_oe, "R10 ack", got_word(), 34'h0);
    end

    // R11: reset in mid-flight drops the pending hit
    @(negedge clk);
    cfg_depth_sel = 2'd0; cfg_extra_lat = 3'd0; cfg_tail_dev = 1'b0; cfg_tail_bus = 1'b0;
    drive_req(1, 0, 1, 1, 0, 22'h000ABC);
    @(negedge clk); drive_req(0, 0, 0, 0, 0, '0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(!res_oe && !ram_drv && ram_addr == '0, "R11 flush", got_word(), 34'h0);
    repeat (6) begin
      @(negedge clk);
      check(!res_found && !ram_drv, "R11 flush", got_word(), 34'h0);
    end

    finish_run();
  end

endmodule